// File: doc/BRIEF.md
# Trace Resource Selector Bank

This block holds a bank of programmable selectors that a trace unit uses to turn many raw resource status signals into a few named conditions. Each programmable selector is configured with a control word that names one resource group and a mask of resources inside that group. The selector reports true when any masked resource is active. An optional invert flag can flip that result. Selectors are grouped as even/odd pairs. A pair output combines its two members as an AND or OR form, with inversion variants chosen by three flag bits.

Selector 0 is fixed false and selector 1 is fixed true, so they form a fixed pair 0. The remaining selectors, up to twice the configured pair count, are written through a simple write port. Writes take effect only while the trace unit reports idle. Both output vectors are registered: they appear one clock after the status inputs are sampled.

Top module: `trace_rsel_bank`

## Requirements
- R1: `sel_o[0]` is always 0, `sel_o[1]` is always 1 and `pair_o[0]` is always 0, whatever is written or applied at the inputs.
- R2: The raw result of a programmable selector is the OR of (mask & group status). The control word holds the mask in bits 15:0 and the group code in bits 19:16. Group codes map as follows: 0 selects the external inputs (mask 3:0). 1 selects the processor comparator inputs (mask 7:0). 2 selects counter-at-zero flags (mask 3:0) together with sequencer states 0 to 3 (mask 7:4). 3 selects single-shot flags (mask 7:0). 4 selects single address hits (mask 15:0). 5 selects address range hits, 6 context ID hits and 7 virtual context ID hits, each with mask 7:0.
- R3: When bit 20 (invert) of a selector's control word is 1, `sel_o` for that selector is the inverse of its raw result.
- R4: A group code from 8 to 15, or an all-zero mask, gives a raw result of 0.
- R5: For pair k ≥ 1, let A be the raw result of selector 2k and B that of selector 2k+1. The code {bit 21 of 2k, bit 20 of 2k, bit 20 of 2k+1} selects the pair output: 000 gives A&B, 010 gives ~A&B, 011 gives ~A&~B, 100 gives ~A|~B, 101 gives ~A|B, and 111 gives A|B.
- R6: The codes 001 and 110 make the pair output 0.
- R7: Bit 21 written to an odd selector has no effect on any output.
- R8: A write is applied only when `wr_en_i` and `idle_i` are both 1 and `wr_idx_i` is between 2 and 2·NUM_PAIRS−1. Any other write is dropped and changes no output.
- R9: `sel_o` and `pair_o` change only at a clock edge. They reflect the status inputs and the control words as they stood just before that edge.
- R10: During and after reset every programmable control word is zero. `sel_o` then reads 2 (only selector 1 true) and `pair_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_i | input | 1 | Trace unit idle; writes are accepted only when high |
| wr_en_i | input | 1 | Control word write strobe |
| wr_idx_i | input | 5 | Selector number being written |
| wr_data_i | input | 32 | Control word (bits 31:22 ignored) |
| ext_i | input | N_EXT | External input status |
| pec_i | input | N_PEC | Processor comparator input status |
| cnt_zero_i | input | N_CNT | Counter-at-zero flags |
| seq_state_i | input | N_SEQ | Sequencer state one-hot |
| ssc_i | input | N_SSC | Single-shot comparator flags |
| sac_i | input | N_SAC | Single address comparator hits |
| arc_i | input | N_ARC | Address range comparator hits |
| cid_i | input | N_CID | Context ID comparator hits |
| vmid_i | input | N_VMID | Virtual context ID comparator hits |
| sel_o | output | 2·NUM_PAIRS | Registered selector results |
| pair_o | output | NUM_PAIRS | Registered pair results |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that the write strobe, index and data are stable at each rising edge, so a dropped write can be seen as an unchanged control word one cycle later. The bench changes every input at the falling edge only. It releases reset after several edges. It randomizes control words and status vectors freely, including reserved group codes, empty masks and the upper word bits, because the block defines an output for each of those values.

// File: rtl/trace_rsel_pkg.sv
package trace_rsel_pkg;

    localparam int MASK_W  = 16;
    localparam int GRP_W   = 4;
    localparam int NUM_GRP = 8;
    localparam int IDX_W   = 5;
    localparam int WORD_W  = 32;

    // Stored control word; upper write bits are never kept
    typedef struct packed {
        logic              pinv;   // pair invert (even selectors only)
        logic              inv;    // selector invert
        logic [GRP_W-1:0]  grp;    // resource group code
        logic [MASK_W-1:0] mask;   // resource select mask
    } rsel_ctl_t;

    typedef enum logic [GRP_W-1:0] {
        GRP_EXT    = 4'd0,
        GRP_PEC    = 4'd1,
        GRP_CNTSEQ = 4'd2,
        GRP_SSC    = 4'd3,
        GRP_SAC    = 4'd4,
        GRP_ARC    = 4'd5,
        GRP_CID    = 4'd6,
        GRP_VMID   = 4'd7
    } rsel_grp_e;

endpackage

// File: rtl/trace_rsel_ctl_regs.sv
module trace_rsel_ctl_regs
    import trace_rsel_pkg::*;
#(
    parameter int NUM_SEL = 16,
    parameter int N_EXT   = 4,
    parameter int N_PEC   = 8,
    parameter int N_CNT   = 4,
    parameter int N_SEQ   = 4,
    parameter int N_SSC   = 8,
    parameter int N_SAC   = 16,
    parameter int N_ARC   = 8,
    parameter int N_CID   = 8,
    parameter int N_VMID  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  idle_i,
    input  logic                  wr_en_i,
    input  logic [IDX_W-1:0]      wr_idx_i,
    input  logic [GRP_W+MASK_W+1:0] wr_data_i,
    output rsel_ctl_t             ctl_o [NUM_SEL]
);

    // Implemented mask bits per group; unimplemented ones are cleared on write
    localparam logic [MASK_W-1:0] VM_EXT  = MASK_W'((32'd1 << N_EXT) - 1);
    localparam logic [MASK_W-1:0] VM_PEC  = MASK_W'((32'd1 << N_PEC) - 1);
    localparam logic [MASK_W-1:0] VM_CNT  = MASK_W'((32'd1 << N_CNT) - 1);
    localparam logic [MASK_W-1:0] VM_SEQ  = MASK_W'(((32'd1 << N_SEQ) - 1) << 4);
    localparam logic [MASK_W-1:0] VM_SSC  = MASK_W'((32'd1 << N_SSC) - 1);
    localparam logic [MASK_W-1:0] VM_SAC  = MASK_W'((32'd1 << N_SAC) - 1);
    localparam logic [MASK_W-1:0] VM_ARC  = MASK_W'((32'd1 << N_ARC) - 1);
    localparam logic [MASK_W-1:0] VM_CID  = MASK_W'((32'd1 << N_CID) - 1);
    localparam logic [MASK_W-1:0] VM_VMID = MASK_W'((32'd1 << N_VMID) - 1);

    rsel_ctl_t ctl_d [NUM_SEL];
    rsel_ctl_t ctl_q [NUM_SEL];
    logic [MASK_W-1:0] vmask;
    logic              accept;

    always_comb begin
        case (wr_data_i[MASK_W+GRP_W-1:MASK_W])
            GRP_EXT:    vmask = VM_EXT;
            GRP_PEC:    vmask = VM_PEC;
            GRP_CNTSEQ: vmask = VM_CNT | VM_SEQ;
            GRP_SSC:    vmask = VM_SSC;
            GRP_SAC:    vmask = VM_SAC;
            GRP_ARC:    vmask = VM_ARC;
            GRP_CID:    vmask = VM_CID;
            GRP_VMID:   vmask = VM_VMID;
            default:    vmask = '0;
        endcase
    end

    assign accept = wr_en_i && idle_i;

    always_comb begin
        for (int s = 0; s < NUM_SEL; s++) begin
            ctl_d[s] = ctl_q[s];
        end
        for (int s = 2; s < NUM_SEL; s++) begin
            if (accept && (wr_idx_i == IDX_W'(s))) begin
                ctl_d[s].pinv = (s % 2 == 0) ? wr_data_i[GRP_W+MASK_W+1] : 1'b0;
                ctl_d[s].inv  = wr_data_i[GRP_W+MASK_W];
                ctl_d[s].grp  = wr_data_i[MASK_W+GRP_W-1:MASK_W];
                ctl_d[s].mask = wr_data_i[MASK_W-1:0] & vmask;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SEL; s++) begin
                ctl_q[s] <= '0;
            end
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ctl_o = ctl_q;

    for (genvar s = 2; s < NUM_SEL; s++) begin : g_chk
        // R8: a write while busy leaves every word untouched
        a_r8_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && !idle_i) |=> $stable(ctl_q[s]));
        if (s % 2 == 1) begin : g_odd
            // R7: odd selectors never hold a pair-invert flag
            a_r7_odd_pinv_clear: assert property (@(posedge clk) disable iff (!rst_n)
                !ctl_q[s].pinv);
        end
    end

endmodule

// File: rtl/trace_rsel_eval.sv
module trace_rsel_eval
    import trace_rsel_pkg::*;
#(
    parameter int NUM_SEL = 16
) (
    input  rsel_ctl_t                          ctl_i [NUM_SEL],
    input  logic [NUM_GRP-1:0][MASK_W-1:0]     stat_i,
    output logic [NUM_SEL-1:0]                 res_o
);

    logic unused_fixed;
    assign unused_fixed = ^{ctl_i[0], ctl_i[1]};

    assign res_o[0] = 1'b0;
    assign res_o[1] = 1'b1;

    for (genvar s = 2; s < NUM_SEL; s++) begin : g_sel
        logic hit;
        always_comb begin
            hit = 1'b0;
            if (!ctl_i[s].grp[GRP_W-1]) begin
                hit = |(ctl_i[s].mask & stat_i[ctl_i[s].grp[GRP_W-2:0]]);
            end
        end
        assign res_o[s] = hit ^ ctl_i[s].inv;
    end

endmodule

// File: rtl/trace_rsel_pair.sv
module trace_rsel_pair #(
    parameter int NUM_PAIRS = 8,
    localparam int NUM_SEL  = 2 * NUM_PAIRS
) (
    input  logic [NUM_PAIRS-1:0] pinv_i,   // pair-invert flag of each even member
    input  logic [NUM_SEL-1:0]   inv_i,    // invert flag of every selector
    input  logic [NUM_SEL-1:0]   res_i,    // selector results after inversion
    output logic [NUM_PAIRS-1:0] pair_o
);

    logic unused_fixed;
    assign unused_fixed = ^{pinv_i[0], inv_i[1:0], res_i[1:0]};

    assign pair_o[0] = 1'b0;

    // With the member inversions already applied, every legal code reduces
    // to an AND of the two results, complemented when the pair flag is set.
    for (genvar k = 1; k < NUM_PAIRS; k++) begin : g_pair
        logic [2:0] code;
        logic       both;
        assign code = {pinv_i[k], inv_i[2*k], inv_i[2*k+1]};
        assign both = res_i[2*k] & res_i[2*k+1];
        always_comb begin
            case (code)
                3'b001, 3'b110: pair_o[k] = 1'b0;
                default:        pair_o[k] = pinv_i[k] ? ~both : both;
            endcase
        end
    end

endmodule

// File: rtl/trace_rsel_bank.sv
module trace_rsel_bank
    import trace_rsel_pkg::*;
#(
    parameter int NUM_PAIRS = 8,
    parameter int N_EXT     = 4,
    parameter int N_PEC     = 8,
    parameter int N_CNT     = 4,
    parameter int N_SEQ     = 4,
    parameter int N_SSC     = 8,
    parameter int N_SAC     = 16,
    parameter int N_ARC     = 8,
    parameter int N_CID     = 8,
    parameter int N_VMID    = 8,
    localparam int NUM_SEL  = 2 * NUM_PAIRS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 idle_i,
    input  logic                 wr_en_i,
    input  logic [4:0]           wr_idx_i,
    input  logic [31:0]          wr_data_i,
    input  logic [N_EXT-1:0]     ext_i,
    input  logic [N_PEC-1:0]     pec_i,
    input  logic [N_CNT-1:0]     cnt_zero_i,
    input  logic [N_SEQ-1:0]     seq_state_i,
    input  logic [N_SSC-1:0]     ssc_i,
    input  logic [N_SAC-1:0]     sac_i,
    input  logic [N_ARC-1:0]     arc_i,
    input  logic [N_CID-1:0]     cid_i,
    input  logic [N_VMID-1:0]    vmid_i,
    output logic [NUM_SEL-1:0]   sel_o,
    output logic [NUM_PAIRS-1:0] pair_o
);

    localparam int CW = GRP_W + MASK_W + 2;

    typedef struct packed {
        logic [NUM_SEL-1:0]   sel;
        logic [NUM_PAIRS-1:0] pair;
    } out_t;

    rsel_ctl_t                      ctl [NUM_SEL];
    logic [NUM_GRP-1:0][MASK_W-1:0] stat;
    logic [NUM_SEL-1:0]             res;
    logic [NUM_SEL-1:0]             inv_v;
    logic [NUM_PAIRS-1:0]           pinv_v;
    logic [NUM_PAIRS-1:0]           pair_c;
    logic                           unused_hi;
    out_t                           out_d, out_q;

    assign unused_hi = ^wr_data_i[31:CW];

    // Group status vectors, zero-extended to the mask width
    always_comb begin
        stat[GRP_EXT]    = MASK_W'(ext_i);
        stat[GRP_PEC]    = MASK_W'(pec_i);
        stat[GRP_CNTSEQ] = MASK_W'({4'(seq_state_i), 4'(cnt_zero_i)});
        stat[GRP_SSC]    = MASK_W'(ssc_i);
        stat[GRP_SAC]    = MASK_W'(sac_i);
        stat[GRP_ARC]    = MASK_W'(arc_i);
        stat[GRP_CID]    = MASK_W'(cid_i);
        stat[GRP_VMID]   = MASK_W'(vmid_i);
    end

    trace_rsel_ctl_regs #(
        .NUM_SEL(NUM_SEL), .N_EXT(N_EXT), .N_PEC(N_PEC), .N_CNT(N_CNT),
        .N_SEQ(N_SEQ), .N_SSC(N_SSC), .N_SAC(N_SAC), .N_ARC(N_ARC),
        .N_CID(N_CID), .N_VMID(N_VMID)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle_i    (idle_i),
        .wr_en_i   (wr_en_i),
        .wr_idx_i  (wr_idx_i),
        .wr_data_i (wr_data_i[CW-1:0]),
        .ctl_o     (ctl)
    );

    trace_rsel_eval #(.NUM_SEL(NUM_SEL)) u_eval (
        .ctl_i  (ctl),
        .stat_i (stat),
        .res_o  (res)
    );

    logic unused_odd;
    always_comb begin
        unused_odd = 1'b0;
        for (int s = 0; s < NUM_SEL; s++) begin
            inv_v[s] = ctl[s].inv;
            if (s % 2 == 1) unused_odd = unused_odd ^ ctl[s].pinv;
        end
        for (int k = 0; k < NUM_PAIRS; k++) begin
            pinv_v[k] = ctl[2*k].pinv;
        end
    end

    trace_rsel_pair #(.NUM_PAIRS(NUM_PAIRS)) u_pair (
        .pinv_i (pinv_v),
        .inv_i  (inv_v),
        .res_i  (res),
        .pair_o (pair_c)
    );

    always_comb begin
        out_d      = out_q;
        out_d.sel  = res;
        out_d.pair = pair_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q.sel  <= NUM_SEL'(2);
            out_q.pair <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign sel_o  = out_q.sel;
    assign pair_o = out_q.pair;

    // R1: fixed selectors and fixed pair never move
    a_r1_fixed_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o[1:0] == 2'b10) && !pair_o[0]);

    for (genvar s = 2; s < NUM_SEL; s++) begin : g_sel_chk
        // R4: reserved group without invert yields false
        a_r4_reserved_group_false: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(ctl[s].grp[GRP_W-1]) && !$past(ctl[s].inv)) |-> !sel_o[s]);
        // R3: empty mask with invert yields true
        a_r3_empty_inverted_true: assert property (@(posedge clk) disable iff (!rst_n)
            (($past(ctl[s].mask) == '0) && $past(ctl[s].inv)) |-> sel_o[s]);
    end

    for (genvar k = 1; k < NUM_PAIRS; k++) begin : g_pair_chk
        // R6: reserved combinations drive the pair output low
        a_r6_reserved_pair_low: assert property (@(posedge clk) disable iff (!rst_n)
            ((({$past(ctl[2*k].pinv), $past(ctl[2*k].inv), $past(ctl[2*k+1].inv)}) == 3'b001) ||
             (({$past(ctl[2*k].pinv), $past(ctl[2*k].inv), $past(ctl[2*k+1].inv)}) == 3'b110))
            |-> !pair_o[k]);
    end

endmodule

// File: tb/trace_rsel_bank_tb.sv
`timescale 1ns/1ps
module trace_rsel_bank_tb;

    localparam int NP = 8;
    localparam int NS = 16;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, idle_i, wr_en_i;
    logic [4:0]  wr_idx_i;
    logic [31:0] wr_data_i;
    logic [3:0]  ext, cnt, seq;
    logic [7:0]  pec, ssc, arc, cid, vmid;
    logic [15:0] sac;
    logic [NS-1:0] sel_o;
    logic [NP-1:0] pair_o;

    logic [31:0] mdl [32];
    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    trace_rsel_bank u_dut (
        .clk(clk), .rst_n(rst_n), .idle_i(idle_i), .wr_en_i(wr_en_i),
        .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
        .ext_i(ext), .pec_i(pec), .cnt_zero_i(cnt), .seq_state_i(seq),
        .ssc_i(ssc), .sac_i(sac), .arc_i(arc), .cid_i(cid), .vmid_i(vmid),
        .sel_o(sel_o), .pair_o(pair_o)
    );

    function automatic logic [15:0] grp_vec(logic [3:0] g);
        case (g)
            4'd0: return {12'b0, ext};
            4'd1: return {8'b0, pec};
            4'd2: return {8'b0, seq, cnt};
            4'd3: return {8'b0, ssc};
            4'd4: return sac;
            4'd5: return {8'b0, arc};
            4'd6: return {8'b0, cid};
            4'd7: return {8'b0, vmid};
            default: return 16'b0;
        endcase
    endfunction

    function automatic logic raw_of(int s);
        if (s == 0) return 1'b0;
        if (s == 1) return 1'b1;
        return |(mdl[s][15:0] & grp_vec(mdl[s][19:16]));
    endfunction

    function automatic logic [NS-1:0] exp_sel();
        logic [NS-1:0] v;
        v = '0;
        v[1] = 1'b1;
        for (int s = 2; s < NS; s++) v[s] = raw_of(s) ^ mdl[s][20];
        return v;
    endfunction

    function automatic logic [NP-1:0] exp_pair();
        logic [NP-1:0] v;
        v = '0;
        for (int k = 1; k < NP; k++) begin
            logic a, b;
            a = raw_of(2*k);
            b = raw_of(2*k+1);
            case ({mdl[2*k][21], mdl[2*k][20], mdl[2*k+1][20]})
                3'b000: v[k] = a & b;
                3'b010: v[k] = ~a & b;
                3'b011: v[k] = ~a & ~b;
                3'b100: v[k] = ~a | ~b;
                3'b101: v[k] = ~a | b;
                3'b111: v[k] = a | b;
                default: v[k] = 1'b0;
            endcase
        end
        return v;
    endfunction

    task automatic compare(string rq, logic [NS-1:0] es, logic [NP-1:0] ep);
        checks++;
        if (sel_o !== es || pair_o !== ep) begin
            errors++;
            $display("FAIL %s: sel_o=%h pair_o=%h expected sel_o=%h pair_o=%h",
                     rq, sel_o, pair_o, es, ep);
        end
    endtask

    task automatic tick_check(string rq);
        @(posedge clk);
        #1;
        compare(rq, exp_sel(), exp_pair());
    endtask

    task automatic rand_stat();
        @(negedge clk);
        ext  = 4'($urandom);  cnt = 4'($urandom);  seq = 4'($urandom);
        pec  = 8'($urandom);  ssc = 8'($urandom);  arc = 8'($urandom);
        cid  = 8'($urandom);  vmid = 8'($urandom); sac = 16'($urandom);
    endtask

    task automatic fill_stat(bit v);
        @(negedge clk);
        ext = {4{v}}; cnt = {4{v}}; seq = {4{v}};
        pec = {8{v}}; ssc = {8{v}}; arc = {8{v}}; cid = {8{v}}; vmid = {8{v}};
        sac = {16{v}};
    endtask

    task automatic wr(int idx, logic [31:0] d, bit idl);
        @(negedge clk);
        idle_i = idl; wr_en_i = 1'b1; wr_idx_i = 5'(idx); wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0; idle_i = 1'b1;
        if (idl && idx >= 2 && idx < NS) begin
            mdl[idx] = d & 32'h003F_FFFF;
            if (idx % 2 == 1) mdl[idx][21] = 1'b0;
        end
    endtask

    function automatic logic [31:0] rand_word();
        logic [3:0]  g;
        logic [15:0] m;
        g = ($urandom % 5 == 0) ? 4'(8 + $urandom % 8) : 4'($urandom % 8);
        m = ($urandom % 6 == 0) ? 16'h0 : 16'($urandom);
        return {10'($urandom), 2'($urandom), g, m};
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run still active, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        rst_n = 1'b0; idle_i = 1'b1; wr_en_i = 1'b0; wr_idx_i = '0; wr_data_i = '0;
        ext = '0; cnt = '0; seq = '0; pec = '0; ssc = '0; arc = '0; cid = '0;
        vmid = '0; sac = '0;
        repeat (3) @(posedge clk);
        #1;
        compare("R10 in reset", exp_sel(), exp_pair());
        @(negedge clk);
        rst_n = 1'b1;
        rand_stat();
        tick_check("R10 after reset");
        fill_stat(1'b1);
        tick_check("R1 R10 all status high");

        // R2: every group, all-ones mask, then random status
        for (int g = 0; g < 8; g++) begin
            wr(2, (32'(g) << 16) | 32'h0000_FFFF, 1'b1);
            wr(3, (32'(g) << 16) | 32'h0000_0001, 1'b1);
            for (int r = 0; r < 3; r++) begin
                rand_stat();
                tick_check("R2 group sweep");
            end
        end
        // R2: counter/sequencer split
        wr(3, 32'h0002_00F0, 1'b1);
        @(negedge clk); cnt = 4'hF; seq = 4'h0;
        tick_check("R2 counters not in sequencer mask");
        @(negedge clk); seq = 4'h4;
        tick_check("R2 sequencer state selected");

        // R4 / R3: empty mask and reserved groups
        fill_stat(1'b1);
        wr(2, 32'h0000_0000, 1'b1);
        tick_check("R4 empty mask false");
        wr(2, 32'h0010_0000, 1'b1);
        tick_check("R3 R4 empty mask inverted");
        wr(2, 32'h0009_FFFF, 1'b1);
        tick_check("R4 reserved group false");
        wr(2, 32'h001C_FFFF, 1'b1);
        tick_check("R3 reserved group inverted");

        // R5 / R6: every pair code against every input combination
        for (int c = 0; c < 8; c++) begin
            wr(4, {10'b0, 1'(c >> 2), 1'(c >> 1), 4'd0, 16'h0001}, 1'b1);
            wr(5, {10'b0, 1'b0, 1'(c), 4'd0, 16'h0002}, 1'b1);
            for (int ab = 0; ab < 4; ab++) begin
                @(negedge clk);
                ext = 4'(ab);
                tick_check((c == 1 || c == 6) ? "R6 reserved pair code" : "R5 pair table");
            end
        end

        // R7: pair flag on an odd selector is ignored
        wr(4, 32'h0000_0001, 1'b1);
        wr(5, 32'h0020_0002, 1'b1);
        @(negedge clk); ext = 4'h3;
        tick_check("R7 odd pair flag ignored, both true");
        @(negedge clk); ext = 4'h1;
        tick_check("R7 odd pair flag ignored, one true");

        // R8: dropped writes
        wr(4, 32'h0010_0000, 1'b0);
        tick_check("R8 write while busy dropped");
        wr(0, 32'h0010_0000, 1'b1);
        wr(1, 32'h0010_0000, 1'b1);
        tick_check("R1 R8 write to fixed selectors dropped");
        wr(20, 32'h0010_0000, 1'b1);
        tick_check("R8 write beyond bank dropped");

        // R9: output holds until the next edge
        for (int i = 0; i < 6; i++) begin
            logic [NS-1:0] ps;
            logic [NP-1:0] pp;
            ps = exp_sel();
            pp = exp_pair();
            rand_stat();
            #1;
            compare("R9 no change before edge", ps, pp);
            tick_check("R9 update at edge");
        end

        // Random configurations and status
        for (int it = 0; it < 40; it++) begin
            for (int s = 2; s < NS; s++) wr(s, rand_word(), ($urandom % 8) != 0);
            for (int r = 0; r < 4; r++) begin
                rand_stat();
                tick_check("R2 R3 R5 R6 R8 random");
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule